// File: doc/BRIEF.md
# Fully Associative Word Cache

This block is a small cache between a processor port and a main-memory port. Each entry holds the upper bits of a word address, one data word and a valid flag. Every request is compared against all entries at once, with no index bits. A read that finds its word is answered in the same cycle. Memory is not touched.

A read that misses stalls the processor and fetches the word from memory. The word is passed straight back and kept in an entry. Empty entries are used first. Once every entry is occupied, a build-time policy picks the victim. It either walks the entries in fill order or draws an index from a free-running pseudo-random register.

Writes always go through to memory. The cache never allocates on a write. If the written word is already cached, its cached copy is updated as well.

Top module: `assoc_cache`

## Requirements
- R1: After reset every entry is invalid, `mem_req` is low, and with no request `cpu_stall` and `cpu_hit` are low. The first read of any address then misses.
- R2: A read whose address bits 31:2 equal those of a valid entry is a hit. In that same cycle `cpu_hit` is 1, `cpu_stall` is 0 and `cpu_rdata` carries the cached word, and no memory request is made. Bits 1:0 of the address take no part in the compare. All 30 upper bits do.
- R3: A read miss holds `cpu_stall` at 1 from its first cycle. The block raises `mem_req` with `mem_we`=0 and the word-aligned address. In the cycle `mem_valid` is 1, `cpu_stall` drops and `cpu_rdata` equals `mem_rdata`.
- R4: A word fetched on a read miss is kept. A later read of the same word hits without a memory access.
- R5: While any entry is invalid, a read miss fills an invalid entry and evicts nothing. Four distinct read misses into an empty four-entry cache leave all four words resident.
- R6: In round-robin mode with every entry valid, a read miss evicts the entry that was filled from memory longest ago.
- R7: In random mode with every entry valid, a read miss evicts exactly one entry. That entry is given by a free-running LFSR (nonzero reset seed) modulo the entry count, so it is not always the oldest.
- R8: Every write is first compared against the stored addresses. It is then sent to memory with `mem_we`=1 and holds `cpu_stall` until `mem_valid`. A write that hits also replaces the cached word, so a later read hits and returns the new value.
- R9: A write miss installs nothing. A repeated write to the same address still misses.
- R10: No two valid entries ever hold the same word address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_req | input | 1 | Processor request, held until `cpu_stall` is low |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid when the request is not stalled |
| cpu_hit | output | 1 | Request matches a valid entry |
| cpu_stall | output | 1 | Request not finished this cycle |
| mem_req | output | 1 | Memory access in progress |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_valid | input | 1 | Memory finishes the access this cycle |
| mem_rdata | input | 32 | Memory read data, sampled with `mem_valid` |

## Verification
The bench builds two copies with four entries each: one in round-robin mode and one in random mode. Both are driven by the same requests and served by a memory with two cycles of latency. With so few entries, four misses fill the cache. After every later miss, each previous resident can be probed with a harmless write, which shows exactly which word was evicted. This makes fill order, the single-victim rule and the non-FIFO random choice all observable at the ports.

// File: rtl/assoc_pkg.sv
package assoc_pkg;

  typedef enum logic [0:0] {
    POL_ROUND  = 1'b0,
    POL_RANDOM = 1'b1
  } repl_e;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_MEM  = 1'b1
  } ctl_e;

endpackage

// File: rtl/assoc_entries.sv
module assoc_entries #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 30,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  logic [TAG_W-1:0]                 wr_tag,
  input  logic [DATA_W-1:0]                wr_data,
  output logic [ENTRIES-1:0][TAG_W-1:0]    tags_o,
  output logic [ENTRIES-1:0][DATA_W-1:0]   data_o,
  output logic [ENTRIES-1:0]               valid_o
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic             sel;
    logic             vld_q;
    logic [TAG_W-1:0] tag_q;
    logic [DATA_W-1:0] dat_q;

    assign sel = wr_en && (wr_idx == IDX_W'(g));

    // valid flag is the only state that needs a defined reset value
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
      end else if (sel) begin
        vld_q <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        tag_q <= wr_tag;
        dat_q <= wr_data;
      end
    end

    assign tags_o[g]  = tag_q;
    assign data_o[g]  = dat_q;
    assign valid_o[g] = vld_q;
  end

endmodule

// File: rtl/assoc_match.sv
module assoc_match #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 30,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0][TAG_W-1:0]  tags_i,
  input  logic [ENTRIES-1:0][DATA_W-1:0] data_i,
  input  logic [ENTRIES-1:0]             valid_i,
  input  logic [TAG_W-1:0]               look_tag,
  output logic [ENTRIES-1:0]             match_o,
  output logic                           hit_o,
  output logic [IDX_W-1:0]               hit_idx_o,
  output logic [DATA_W-1:0]              hit_data_o
);

  // one comparator per entry, all evaluated in parallel
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (tags_i[g] == look_tag);
  end

  assign hit_o = |match_o;

  // at most one entry matches, so an OR of masked words selects it
  always_comb begin
    hit_idx_o  = '0;
    hit_data_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_o[i]) begin
        hit_idx_o  = IDX_W'(i);
        hit_data_o = hit_data_o | data_i[i];
      end
    end
  end

endmodule

// File: rtl/assoc_victim.sv
module assoc_victim #(
  parameter int              ENTRIES   = 8,
  parameter assoc_pkg::repl_e POLICY   = assoc_pkg::POL_ROUND,
  parameter int              LFSR_W    = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_i,
  input  logic               advance,
  output logic [IDX_W-1:0]   victim_o
);

  logic             any_free;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] pick;

  // lowest-numbered empty entry
  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        free_idx = IDX_W'(i);
      end
    end
  end

  assign any_free = ~&valid_i;
  assign victim_o = any_free ? free_idx : pick;

  if (POLICY == assoc_pkg::POL_ROUND) begin : g_round
    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] ptr_d;

    always_comb begin
      ptr_d = ptr_q;
      if (advance) begin
        ptr_d = (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ptr_q <= '0;
      end else begin
        ptr_q <= ptr_d;
      end
    end

    assign pick = ptr_q;
  end else begin : g_random
    logic [LFSR_W-1:0] lfsr_q;
    logic [LFSR_W-1:0] lfsr_d;
    logic              unused_adv;

    assign unused_adv = advance;

    always_comb begin
      lfsr_d = lfsr_q >> 1;
      if (lfsr_q[0]) begin
        lfsr_d = lfsr_d ^ LFSR_TAPS;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lfsr_q <= LFSR_SEED;
      end else begin
        lfsr_q <= lfsr_d;
      end
    end

    assign pick = IDX_W'(lfsr_q % LFSR_W'(ENTRIES));
  end

endmodule

// File: rtl/assoc_cache.sv
module assoc_cache #(
  parameter int               ENTRIES   = 8,
  parameter int               ADDR_W    = 32,
  parameter int               DATA_W    = 32,
  parameter assoc_pkg::repl_e POLICY    = assoc_pkg::POL_ROUND,
  parameter int               LFSR_W    = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_hit,
  output logic              cpu_stall,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_valid,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam int OFF_W = $clog2(DATA_W / 8);
  localparam int TAG_W = ADDR_W - OFF_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  // reset: asserted at once, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[1];

  logic [TAG_W-1:0] look_tag;
  logic [OFF_W-1:0] unused_off;

  assign look_tag   = cpu_addr[ADDR_W-1:OFF_W];
  assign unused_off = cpu_addr[OFF_W-1:0];

  // storage and lookup
  logic [ENTRIES-1:0][TAG_W-1:0]  tags_w;
  logic [ENTRIES-1:0][DATA_W-1:0] data_w;
  logic [ENTRIES-1:0]             valid_w;
  logic [ENTRIES-1:0]             match_w;
  logic                           hit_w;
  logic [IDX_W-1:0]               hit_idx_w;
  logic [DATA_W-1:0]              hit_data_w;
  logic [IDX_W-1:0]               victim_w;

  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [DATA_W-1:0] wr_data;
  logic             install;
  logic             upd_hit;

  assoc_entries #(
    .ENTRIES (ENTRIES),
    .TAG_W   (TAG_W),
    .DATA_W  (DATA_W)
  ) u_ent (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_tag  (look_tag),
    .wr_data (wr_data),
    .tags_o  (tags_w),
    .data_o  (data_w),
    .valid_o (valid_w)
  );

  assoc_match #(
    .ENTRIES (ENTRIES),
    .TAG_W   (TAG_W),
    .DATA_W  (DATA_W)
  ) u_cmp (
    .tags_i     (tags_w),
    .data_i     (data_w),
    .valid_i    (valid_w),
    .look_tag   (look_tag),
    .match_o    (match_w),
    .hit_o      (hit_w),
    .hit_idx_o  (hit_idx_w),
    .hit_data_o (hit_data_w)
  );

  assoc_victim #(
    .ENTRIES   (ENTRIES),
    .POLICY    (POLICY),
    .LFSR_W    (LFSR_W),
    .LFSR_TAPS (LFSR_TAPS),
    .LFSR_SEED (LFSR_SEED)
  ) u_vic (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .valid_i  (valid_w),
    .advance  (install),
    .victim_o (victim_w)
  );

  // control
  assoc_pkg::ctl_e state_q;
  assoc_pkg::ctl_e state_d;
  logic            busy;
  logic            need_mem;
  logic            done;

  assign busy     = (state_q == assoc_pkg::ST_MEM);
  assign need_mem = cpu_req && (cpu_we || !hit_w);
  assign done     = busy && mem_valid;

  always_comb begin
    state_d = state_q;
    case (state_q)
      assoc_pkg::ST_IDLE: if (need_mem) state_d = assoc_pkg::ST_MEM;
      assoc_pkg::ST_MEM:  if (mem_valid) state_d = assoc_pkg::ST_IDLE;
      default:            state_d = assoc_pkg::ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= assoc_pkg::ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // entry update: install on read fill, refresh on write hit
  assign install = done && !cpu_we;
  assign upd_hit = done && cpu_we && hit_w;
  assign wr_en   = install || upd_hit;
  assign wr_idx  = install ? victim_w : hit_idx_w;
  assign wr_data = install ? mem_rdata : cpu_wdata;

  // processor side
  assign cpu_hit   = cpu_req && hit_w;
  assign cpu_stall = busy ? !mem_valid : need_mem;
  assign cpu_rdata = busy ? mem_rdata : hit_data_w;

  // memory side
  assign mem_req   = busy;
  assign mem_we    = cpu_we;
  assign mem_addr  = {look_tag, {OFF_W{1'b0}}};
  assign mem_wdata = cpu_wdata;

endmodule

// File: rtl/assoc_cache_chk.sv
module assoc_cache_chk #(
  parameter int ENTRIES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cpu_req,
  input logic               cpu_we,
  input logic               cpu_hit,
  input logic               cpu_stall,
  input logic               mem_req,
  input logic               mem_we,
  input logic               mem_valid,
  input logic [ENTRIES-1:0] valid_vec,
  input logic [ENTRIES-1:0] match_vec
);

  // R3: stall stays up while memory has not answered
  a_r3_stall_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |-> cpu_stall);

  // R3: memory request ends right after the answer
  a_r3_release_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_valid) |=> !mem_req);

  // R2: a read hit is served without stalling
  a_r2_hit_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_we && cpu_hit && !mem_req) |-> !cpu_stall);

  // R10: never two matching entries
  a_r10_unique_entries: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

  // R4: an entry once valid stays valid
  a_r4_valid_kept: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(valid_vec) >= $countones($past(valid_vec)));

  // R5: a fill into a non-full cache adds exactly one entry
  a_r5_fill_free_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_valid && !mem_we && !(&valid_vec))
    |=> ($countones(valid_vec) == $countones($past(valid_vec)) + 1));

  // R9: a write completion never adds an entry
  a_r9_write_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_valid && mem_we)
    |=> ($countones(valid_vec) == $countones($past(valid_vec))));

endmodule

bind assoc_cache assoc_cache_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_req   (cpu_req),
  .cpu_we    (cpu_we),
  .cpu_hit   (cpu_hit),
  .cpu_stall (cpu_stall),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_valid (mem_valid),
  .valid_vec (valid_w),
  .match_vec (match_w)
);

// File: tb/sim_assoc_cache.sv
`timescale 1ns/1ps
module sim_assoc_cache;

  localparam int NE  = 4;
  localparam int LAT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req0 = 1'b0, req1 = 1'b0, we_i = 1'b0;
  logic [31:0] addr_i = '0, wd_i = '0;

  logic [31:0] rdata0, rdata1, maddr0, maddr1, mwd0, mwd1;
  logic        hit0, hit1, stall0, stall1, mreq0, mreq1, mwe0, mwe1;
  logic        mv0 = 1'b0, mv1 = 1'b0;
  logic [31:0] mrd0 = '0, mrd1 = '0;
  int          lc0 = 0, lc1 = 0, mc0 = 0, mc1 = 0;

  int total = 0;
  int bad   = 0;

  // memory model: default pattern plus written words
  logic [31:0] wa [64];
  logic [31:0] wdv [64];
  int          wn = 0;

  function automatic logic [31:0] memrd(input logic [31:0] a);
    logic [31:0] w;
    w = {a[31:2], 2'b00};
    for (int i = 0; i < wn; i++) if (wa[i] == w) return wdv[i];
    return w ^ 32'hC3A5_1E0F;
  endfunction

  task automatic memwr(input logic [31:0] a, input logic [31:0] d);
    logic [31:0] w;
    w = {a[31:2], 2'b00};
    for (int i = 0; i < wn; i++) begin
      if (wa[i] == w) begin
        wdv[i] = d;
        return;
      end
    end
    wa[wn] = w;
    wdv[wn] = d;
    wn++;
  endtask

  assoc_cache #(.ENTRIES(NE), .POLICY(assoc_pkg::POL_ROUND)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_req(req0), .cpu_we(we_i), .cpu_addr(addr_i),
    .cpu_wdata(wd_i), .cpu_rdata(rdata0), .cpu_hit(hit0), .cpu_stall(stall0),
    .mem_req(mreq0), .mem_we(mwe0), .mem_addr(maddr0), .mem_wdata(mwd0),
    .mem_valid(mv0), .mem_rdata(mrd0));

  assoc_cache #(.ENTRIES(NE), .POLICY(assoc_pkg::POL_RANDOM)) u1 (
    .clk(clk), .rst_n(rst_n), .cpu_req(req1), .cpu_we(we_i), .cpu_addr(addr_i),
    .cpu_wdata(wd_i), .cpu_rdata(rdata1), .cpu_hit(hit1), .cpu_stall(stall1),
    .mem_req(mreq1), .mem_we(mwe1), .mem_addr(maddr1), .mem_wdata(mwd1),
    .mem_valid(mv1), .mem_rdata(mrd1));

  // memory responders, LAT idle cycles then one valid cycle
  always @(negedge clk) begin
    if (mv0) mv0 = 1'b0;
    else if (mreq0) begin
      if (lc0 == LAT) begin
        lc0 = 0; mv0 = 1'b1; mc0++;
        if (mwe0) memwr(maddr0, mwd0); else mrd0 = memrd(maddr0);
      end else lc0++;
    end
  end

  always @(negedge clk) begin
    if (mv1) mv1 = 1'b0;
    else if (mreq1) begin
      if (lc1 == LAT) begin
        lc1 = 0; mv1 = 1'b1; mc1++;
        if (mwe1) memwr(maddr1, mwd1); else mrd1 = memrd(maddr1);
      end else lc1++;
    end
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // results of the last access
  logic        h0, h1, sf0, sf1;
  logic [31:0] rd0, rd1;

  task automatic access(input logic we, input logic [31:0] a, input logic [31:0] d);
    logic d0, d1;
    @(negedge clk);
    req0 = 1'b1; req1 = 1'b1; we_i = we; addr_i = a; wd_i = d;
    #1;
    h0 = hit0; h1 = hit1; sf0 = stall0; sf1 = stall1;
    d0 = 1'b0; d1 = 1'b0;
    forever begin
      if (!d0 && !stall0) begin rd0 = rdata0; d0 = 1'b1; end
      if (!d1 && !stall1) begin rd1 = rdata1; d1 = 1'b1; end
      if (d0 && d1) break;
      @(negedge clk);
      if (d0) req0 = 1'b0;
      if (d1) req1 = 1'b0;
      #1;
    end
    @(negedge clk);
    req0 = 1'b0; req1 = 1'b0;
  endtask

  task automatic probe(input logic [31:0] a);
    access(1'b1, a, memrd(a));
  endtask

  task automatic finish_up;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    finish_up();
  end

  localparam logic [31:0] A0 = 32'h0000_1000;
  localparam logic [31:0] A1 = 32'h8000_1000;
  localparam logic [31:0] A2 = 32'h0000_1004;
  localparam logic [31:0] A3 = 32'h0000_1008;
  localparam logic [31:0] B0 = 32'h0000_2000;

  logic [31:0] r0 [NE];
  logic [31:0] r1 [NE];

  initial begin
    int m0, m1, e0, e1, pc;
    logic nonfifo;
    logic [31:0] nw;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    // R1: idle after reset
    chk("R1 stall", {31'b0, stall0 | stall1}, 32'd0);
    chk("R1 mem_req", {31'b0, mreq0 | mreq1}, 32'd0);
    chk("R1 hit", {31'b0, hit0 | hit1}, 32'd0);

    // R1/R3: first read misses and returns memory word
    access(1'b0, A0, 32'h0);
    chk("R1 first read miss", {30'b0, h1, h0}, 32'd0);
    chk("R3 stall on miss", {30'b0, sf1, sf0}, 32'd3);
    chk("R3 miss data u0", rd0, memrd(A0));
    chk("R3 miss data u1", rd1, memrd(A0));
    chk("R3 one fetch", mc0, 32'd1);

    // R2/R4: byte offset ignored, hit with no memory access
    pc = mc0;
    access(1'b0, A0 + 32'd3, 32'h0);
    chk("R2 offset hit", {30'b0, h1, h0}, 32'd3);
    chk("R2 no stall", {30'b0, sf1, sf0}, 32'd0);
    chk("R2 hit data", rd0, memrd(A0));
    chk("R4 no memory access", mc0, pc);

    // R2: top address bit is part of the compare
    access(1'b0, A1, 32'h0);
    chk("R2 full tag miss", {30'b0, h1, h0}, 32'd0);
    chk("R2 full tag data", rd0, memrd(A1));
    access(1'b0, A2, 32'h0);
    access(1'b0, A3, 32'h0);

    // R5/R10: four distinct words resident after four fills
    access(1'b0, A0, 32'h0);
    chk("R5 A0 resident", {30'b0, h1, h0}, 32'd3);
    access(1'b0, A1, 32'h0);
    chk("R5 A1 resident", {30'b0, h1, h0}, 32'd3);
    access(1'b0, A2, 32'h0);
    chk("R10 A2 resident", {30'b0, h1, h0}, 32'd3);
    access(1'b0, A3, 32'h0);
    chk("R5 A3 resident", {30'b0, h1, h0}, 32'd3);

    // R8: write hit goes through and refreshes the entry
    pc = mc0;
    access(1'b1, A2, 32'hDEAD_BEEF);
    chk("R8 write compare hit", {30'b0, h1, h0}, 32'd3);
    chk("R8 write stalls", {30'b0, sf1, sf0}, 32'd3);
    chk("R8 write to memory", mc0, pc + 1);
    chk("R8 memory value", memrd(A2), 32'hDEAD_BEEF);
    pc = mc0;
    access(1'b0, A2, 32'h0);
    chk("R8 read after write hit", {30'b0, h1, h0}, 32'd3);
    chk("R8 refreshed data u0", rd0, 32'hDEAD_BEEF);
    chk("R8 refreshed data u1", rd1, 32'hDEAD_BEEF);
    chk("R8 no fetch", mc0, pc);

    // R9: write miss does not allocate
    pc = mc0;
    access(1'b1, B0, 32'h1234_5678);
    chk("R9 write miss", {30'b0, h1, h0}, 32'd0);
    chk("R9 write reached memory", mc0, pc + 1);
    access(1'b1, B0, 32'h1234_5679);
    chk("R9 still miss", {30'b0, h1, h0}, 32'd0);
    access(1'b0, A0, 32'h0);
    chk("R9 residents kept", {30'b0, h1, h0}, 32'd3);

    // R6/R7: eviction rounds on a full cache
    r0[0] = A0; r0[1] = A1; r0[2] = A2; r0[3] = A3;
    for (int i = 0; i < NE; i++) r1[i] = r0[i];
    nonfifo = 1'b0;
    for (int k = 0; k < 8; k++) begin
      nw = 32'h0001_0000 + 32'(k) * 32'd4;
      access(1'b0, nw, 32'h0);
      chk("R3 new word misses", {30'b0, h1, h0}, 32'd0);
      chk("R3 new word data", rd1, memrd(nw));
      m0 = 0; e0 = 0; m1 = 0; e1 = 0;
      for (int i = 0; i < NE; i++) begin
        probe(r0[i]);
        if (!h0) begin m0++; e0 = i; end
      end
      for (int i = 0; i < NE; i++) begin
        probe(r1[i]);
        if (!h1) begin if (m1 == 0) e1 = i; m1++; end
      end
      chk("R6 one eviction", m0, 32'd1);
      chk("R6 oldest evicted", e0, 32'd0);
      chk("R7 one eviction", m1, 32'd1);
      if (e1 != 0) nonfifo = 1'b1;
      for (int i = e0; i < NE - 1; i++) r0[i] = r0[i+1];
      r0[NE-1] = nw;
      for (int i = e1; i < NE - 1; i++) r1[i] = r1[i+1];
      r1[NE-1] = nw;
    end
    chk("R7 victim not always oldest", {31'b0, nonfifo}, 32'd1);

    finish_up();
  end

endmodule